// File: doc/BRIEF.md
# Cascaded LUT Wide-Fan-In Combiner

This block builds a single Boolean function of many inputs from a chain of small lookup-table slices. Each slice owns a 16-entry truth table and looks at its own group of four inputs. The one-bit results are merged serially along the chain. One configuration bit selects how the whole chain merges: every slice must be true (conjunction), or any slice may be true (disjunction). The disjunction runs on the same conjunction hardware by inverting each slice result on entry and inverting the chain result again at the end. With all slices configured, a chain of `N_SLICES` slices evaluates any function that is a conjunction or disjunction of 4-input sub-functions over `4*N_SLICES` variables. A wide address comparator is the typical use: four slices in conjunction mode, each matching one nibble, decode a 16-bit address.

Alongside the function, the block computes where each slice would sit in a row of logic-array blocks. A block holds `SLICES_PER_BLOCK` slices. A chain that outgrows one block continues two block positions further on, so it always stays on blocks with the same parity as its first block. The row is split in two halves by an embedded memory at its centre. A chain may not cross that centre or run off the end of the row. When it would, the block raises a placement error and forces the function output low. All outputs are registered behind a clock enable.

Top module: `cascade_combiner`

## Requirements
- R1: Slice k selects bit `16*k + v` of `cfg_tt`, where v is the unsigned value of `d_in[4k+3:4k]`.
- R2: With `cfg_or` = 0 the function output is 1 exactly when every slice's selected bit is 1.
- R3: With `cfg_or` = 1 the function output is 1 exactly when at least one slice's selected bit is 1.
- R4: Field k of `blk_idx`, bits `[IDX_W*k +: IDX_W]`, equals `start_blk + 2*floor(k/SLICES_PER_BLOCK)`. With the defaults IDX_W is 6.
- R5: `place_err` is 1 exactly when some slice's block index lies outside the row (index >= `BLOCKS_PER_ROW`) or lies in the other half from `start_blk`. The right half starts at index `BLOCKS_PER_ROW/2`, which is 18 by default.
- R6: While the placement is in error, `f_out` is 0 regardless of the truth tables and inputs.
- R7: Outputs take the value computed from the inputs present at a rising clock edge where `en` = 1. At an edge where `en` = 0 they hold.
- R8: While `rst_n` is low, `f_out`, `place_err` and `blk_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output registers |
| cfg_or | input | 1 | Merge mode: 0 conjunction, 1 disjunction |
| cfg_tt | input | 16*N_SLICES | Concatenated truth tables, slice k in bits [16k+15:16k] |
| start_blk | input | $clog2(BLOCKS_PER_ROW) | Block index of the chain's first slice |
| d_in | input | 4*N_SLICES | Function inputs, slice k reads bits [4k+3:4k] |
| f_out | output | 1 | Registered function result |
| place_err | output | 1 | Registered placement error flag |
| blk_idx | output | IDX_W*N_SLICES | Registered block index per slice |

## Verification
The assertions assume `start_blk` is a valid block of the row, below `BLOCKS_PER_ROW`. They also assume `en`, `cfg_or`, `cfg_tt`, `start_blk` and `d_in` carry known values at every sampled edge after reset. The stimulus only draws start positions in the range 0 to 35, and it drives every input to a defined value before reset is released. It changes inputs only on falling edges, so the values seen at each rising edge are stable. The random phase reduces its drawn start values modulo the row width, so it stays within the same assumption.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  localparam int LUT_INS  = 4;
  localparam int LUT_BITS = 1 << LUT_INS;

  typedef enum logic {
    MERGE_AND = 1'b0,
    MERGE_OR  = 1'b1
  } merge_mode_e;
endpackage

// File: rtl/lut_slice.sv
module lut_slice
  import cascade_pkg::*;
(
  input  logic [LUT_BITS-1:0] tt,
  input  logic [LUT_INS-1:0]  sel,
  input  logic                invert,
  input  logic                cas_in,
  output logic                cas_out
);
  logic lut_bit;
  logic term;

  always_comb begin
    lut_bit = tt[sel];
    term    = lut_bit ^ invert;
    cas_out = cas_in & term;
  end
endmodule

// File: rtl/placement_map.sv
module placement_map #(
  parameter int N_SLICES         = 12,
  parameter int SLICES_PER_BLOCK = 8,
  parameter int BLOCKS_PER_ROW   = 36,
  parameter int SW               = 6,
  parameter int IDX_W            = 6
) (
  input  logic [SW-1:0]             start,
  output logic [N_SLICES*IDX_W-1:0] idx_flat,
  output logic                      err
);
  localparam int HALF = BLOCKS_PER_ROW / 2;
  localparam logic [IDX_W-1:0] LIM_I  = IDX_W'(BLOCKS_PER_ROW);
  localparam logic [IDX_W-1:0] HALF_I = IDX_W'(HALF);
  localparam logic [SW-1:0]    HALF_S = SW'(HALF);

  logic [N_SLICES-1:0] off;
  logic start_right;

  assign start_right = (start >= HALF_S);

  for (genvar k = 0; k < N_SLICES; k++) begin : g_pos
    localparam int OFS = 2 * (k / SLICES_PER_BLOCK);
    logic [IDX_W-1:0] idx;
    always_comb begin
      idx    = IDX_W'(start) + IDX_W'(OFS);
      off[k] = (idx >= LIM_I) | ((idx >= HALF_I) != start_right);
    end
    assign idx_flat[k*IDX_W +: IDX_W] = idx;
  end

  assign err = |off;
endmodule

// File: rtl/cascade_combiner.sv
module cascade_combiner
  import cascade_pkg::*;
#(
  parameter int N_SLICES         = 12,
  parameter int SLICES_PER_BLOCK = 8,
  parameter int BLOCKS_PER_ROW   = 36,
  localparam int SW      = $clog2(BLOCKS_PER_ROW),
  localparam int MAX_IDX = BLOCKS_PER_ROW - 1 + 2 * ((N_SLICES - 1) / SLICES_PER_BLOCK),
  localparam int IDX_W   = $clog2(MAX_IDX + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         cfg_or,
  input  logic [N_SLICES*LUT_BITS-1:0] cfg_tt,
  input  logic [SW-1:0]                start_blk,
  input  logic [N_SLICES*LUT_INS-1:0]  d_in,
  output logic                         f_out,
  output logic                         place_err,
  output logic [N_SLICES*IDX_W-1:0]    blk_idx
);
  localparam logic [IDX_W-1:0] LIM_I = IDX_W'(BLOCKS_PER_ROW);

  merge_mode_e mode;
  logic [N_SLICES:0] chain;
  logic [N_SLICES*IDX_W-1:0] idx_next;
  logic err_next;
  logic f_next;

  assign mode     = merge_mode_e'(cfg_or);
  assign chain[0] = 1'b1;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    lut_slice u_slice (
      .tt     (cfg_tt[k*LUT_BITS +: LUT_BITS]),
      .sel    (d_in[k*LUT_INS +: LUT_INS]),
      .invert (mode == MERGE_OR),
      .cas_in (chain[k]),
      .cas_out(chain[k+1])
    );

    // R2/R3: a broken link can never be healed further down the chain
    a_r2_chain_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !chain[k] |-> !chain[k+1]);
  end

  placement_map #(
    .N_SLICES        (N_SLICES),
    .SLICES_PER_BLOCK(SLICES_PER_BLOCK),
    .BLOCKS_PER_ROW  (BLOCKS_PER_ROW),
    .SW              (SW),
    .IDX_W           (IDX_W)
  ) u_map (
    .start   (start_blk),
    .idx_flat(idx_next),
    .err     (err_next)
  );

  for (genvar k = 0; k < N_SLICES; k++) begin : g_chk
    a_r4_same_parity: assert property (@(posedge clk) disable iff (!rst_n)
      idx_next[k*IDX_W] == start_blk[0]);
    a_r5_ok_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      !place_err |-> (blk_idx[k*IDX_W +: IDX_W] < LIM_I));
  end

  always_comb begin
    if (err_next)               f_next = 1'b0;
    else if (mode == MERGE_OR)  f_next = ~chain[N_SLICES];
    else                        f_next = chain[N_SLICES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_out     <= 1'b0;
      place_err <= 1'b0;
      blk_idx   <= '0;
    end else if (en) begin
      f_out     <= f_next;
      place_err <= err_next;
      blk_idx   <= idx_next;
    end
  end

  a_r6_err_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    place_err |-> !f_out);
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(f_out) && $stable(place_err) && $stable(blk_idx)));
endmodule

// File: tb/cascade_combiner_tb.sv
module cascade_combiner_tb_top;
  localparam int N    = 12;
  localparam int SPB  = 8;
  localparam int BLKS = 36;
  localparam int SW   = 6;
  localparam int IW   = 6;

  logic clk = 1'b0;
  logic rst_n, en, cfg_or;
  logic [N*16-1:0] cfg_tt;
  logic [SW-1:0]   start_blk;
  logic [N*4-1:0]  d_in;
  logic            f_out, place_err;
  logic [N*IW-1:0] blk_idx;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  cascade_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_or(cfg_or), .cfg_tt(cfg_tt),
    .start_blk(start_blk), .d_in(d_in), .f_out(f_out),
    .place_err(place_err), .blk_idx(blk_idx)
  );

  typedef struct packed {
    logic        m;
    logic [5:0]  st;
    logic [15:0] pat;
    logic [47:0] d;
    logic        e;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 6'd0,  16'hFFFF, 48'h0,            1'b0},
    '{1'b0, 6'd0,  16'h0000, 48'h0,            1'b0},
    '{1'b1, 6'd0,  16'h0000, 48'h123456789ABC, 1'b0},
    '{1'b1, 6'd0,  16'hFFFF, 48'h0,            1'b0},
    '{1'b0, 6'd1,  16'hAAAA, 48'h111111111111, 1'b0},
    '{1'b0, 6'd1,  16'hAAAA, 48'h111111111110, 1'b0},
    '{1'b1, 6'd2,  16'hAAAA, 48'h000000000100, 1'b0},
    '{1'b0, 6'd16, 16'hFFFF, 48'h0,            1'b1},
    '{1'b0, 6'd33, 16'hFFFF, 48'h0,            1'b0},
    '{1'b0, 6'd34, 16'hFFFF, 48'h0,            1'b1},
    '{1'b1, 6'd17, 16'hFFFF, 48'h0,            1'b1},
    '{1'b0, 6'd15, 16'h6996, 48'h356A9C0FF035, 1'b0}
  };

  function automatic logic ref_err(input logic [SW-1:0] st);
    logic e = 1'b0;
    for (int k = 0; k < N; k++) begin
      int ix = int'(st) + 2 * (k / SPB);
      if (ix >= BLKS || ((ix >= BLKS/2) != (int'(st) >= BLKS/2))) e = 1'b1;
    end
    return e;
  endfunction

  function automatic logic ref_f(input logic m, input logic [N*16-1:0] tt,
                                 input logic [N*4-1:0] d, input logic [SW-1:0] st);
    logic all1 = 1'b1;
    logic any1 = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic b = tt[16*k + int'(d[4*k +: 4])];
      all1 &= b;
      any1 |= b;
    end
    if (ref_err(st)) return 1'b0;
    return m ? any1 : all1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idx(input string req, input logic [SW-1:0] st);
    for (int k = 0; k < N; k++)
      chk(req, 64'(blk_idx[k*IW +: IW]), 64'(int'(st) + 2 * (k / SPB)));
  endtask

  task automatic apply(input logic m, input logic [N*16-1:0] tt,
                       input logic [N*4-1:0] d, input logic [SW-1:0] st);
    @(negedge clk);
    cfg_or = m; cfg_tt = tt; d_in = d; start_blk = st; en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [N*16-1:0] tt;
    logic [N*4-1:0]  d;
    rst_n = 1'b0; en = 1'b1; cfg_or = 1'b0; cfg_tt = '1; d_in = '0; start_blk = 6'd3;
    repeat (3) @(negedge clk);
    // R8: reset holds outputs low even with inputs that give f=1
    chk("R8 f_out", 64'(f_out), 64'd0);
    chk("R8 place_err", 64'(place_err), 64'd0);
    chk("R8 blk_idx", 64'(blk_idx), 64'd0);
    rst_n = 1'b1;

    // vector table: R2, R3, R4, R5, R6
    for (int i = 0; i < 12; i++) begin
      apply(VEC[i].m, {N{VEC[i].pat}}, VEC[i].d, VEC[i].st);
      chk(VEC[i].m ? "R3 f_out" : "R2 f_out", 64'(f_out),
          64'(ref_f(VEC[i].m, {N{VEC[i].pat}}, VEC[i].d, VEC[i].st)));
      chk("R5 place_err", 64'(place_err), 64'(VEC[i].e));
      if (VEC[i].e) chk("R6 forced zero", 64'(f_out), 64'd0);
      check_idx("R4 blk_idx", VEC[i].st);
    end

    // R1: scan every entry of slice 5 with the others transparent
    for (int v = 0; v < 16; v++) begin
      tt = '1;
      tt[16*5 +: 16] = 16'h8421 ^ 16'(1 << v);
      d = '0;
      d[4*5 +: 4] = 4'(v);
      apply(1'b0, tt, d, 6'd4);
      chk("R1 lut select", 64'(f_out), 64'(tt[16*5 + v]));
    end

    // R2: 16-bit address decode with four slices, key 0xB7E2
    tt = '1;
    for (int k = 0; k < 4; k++) tt[16*k +: 16] = 16'(1 << ((16'hB7E2 >> (4*k)) & 15));
    d = '0; d[15:0] = 16'hB7E2;
    apply(1'b0, tt, d, 6'd0);
    chk("R2 decode hit", 64'(f_out), 64'd1);
    d[15:0] = 16'hB7E3;
    apply(1'b0, tt, d, 6'd0);
    chk("R2 decode miss", 64'(f_out), 64'd0);

    // R6: disjunction with every slice true, placed across the centre
    apply(1'b1, '1, '0, 6'd17);
    chk("R6 forced zero or-mode", 64'(f_out), 64'd0);

    // R7: en low holds outputs while inputs change
    apply(1'b0, '1, '0, 6'd2);
    @(negedge clk);
    en = 1'b0; cfg_tt = '0; start_blk = 6'd20;
    @(negedge clk);
    @(negedge clk);
    chk("R7 hold f_out", 64'(f_out), 64'd1);
    chk("R7 hold place_err", 64'(place_err), 64'd0);
    check_idx("R7 hold blk_idx", 6'd2);
    en = 1'b1;
    @(negedge clk);
    chk("R7 update f_out", 64'(f_out), 64'd0);
    check_idx("R7 update blk_idx", 6'd20);

    // random configurations in both merge modes: R1 R2 R3 R4 R5
    for (int i = 0; i < 300; i++) begin
      logic m = 1'($urandom);
      logic [SW-1:0] st = SW'($urandom % BLKS);
      for (int k = 0; k < N; k++) begin
        tt[16*k +: 16] = m ? 16'($urandom & $urandom & $urandom)
                           : 16'($urandom | $urandom | $urandom);
        d[4*k +: 4] = 4'($urandom);
      end
      apply(m, tt, d, st);
      chk(m ? "R3 random" : "R2 random", 64'(f_out), 64'(ref_f(m, tt, d, st)));
      chk("R5 random", 64'(place_err), 64'(ref_err(st)));
      chk("R4 random", 64'(blk_idx[(N-1)*IW +: IW]), 64'(int'(st) + 2 * ((N-1) / SPB)));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule